// File: doc/BRIEF.md
# SD Command and Response Engine

This block issues a single command on the CMD line of an SD or MMC card and collects the answer. A caller presents a 6-bit command index, a 32-bit argument and a response kind together with `req_valid` while the engine is idle. The engine serialises a 48-bit command token, one bit per clock, with its own CRC7. Unless the kind says no answer is expected, it then releases the line and hunts for the card's start bit. It shifts in a 48-bit or a 136-bit reply and checks the reply's leading bits and its CRC7. It finishes with a one-cycle `done` pulse.

Each clock of `clk` is one CMD bit period. A clock divider upstream is expected to set the bus rate. The reply payload comes out on a 128-bit port as big-endian 32-bit words, with the first word in the top bits. Three error flags report a missing reply, a bad header and a CRC mismatch. For the kind that signals busy on DAT0, completion also waits for DAT0 to return high. Data transfers, clocking and card power belong to other blocks.

Top module: `sd_cmd_engine`

## Requirements
- R1: The cycle after a request is accepted, `cmd_oe` rises and `cmd_out` carries the 48-bit token MSB first for exactly 48 cycles. The token is start bit 0, transmission bit 1, the 6-bit index, the argument MSB first, CRC7 (x^7+x^3+1, zero seed) over those 40 bits, then a stop bit 1. Outside the token, `cmd_out` is 1 and `cmd_oe` is 0.
- R2: A request is taken only when `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. `req_valid` pulses while busy are ignored and do not alter the token being sent.
- R3: Response kind encoding is 0 none, 1 short, 2 short with busy, 3 long, 4 short without CRC check; codes 5 to 7 act as none. For kind none, `done` is high in the 49th cycle after the accepting edge (48 edges later), with all flags 0 and `rsp_data` 0.
- R4: After the last token bit, `cmd_in` is sampled on every edge. The first 0 is the reply's start bit and counts as its first bit. A reply is 48 bits for kinds 1, 2 and 4, and 136 bits for kind 3. `done` rises right after the edge that samples the last bit (kinds 1, 3, 4).
- R5: If `RSP_TIMEOUT` consecutive samples after the token are all 1, `done` rises after the last of them with `err_timeout`=1, `err_hdr`=0, `err_crc`=0 and `rsp_data`=0. A start bit on the final allowed sample is still accepted.
- R6: For a short reply, reply bits 39..8 (counting the start bit as bit 47) appear on `rsp_data[127:96]`, and `rsp_data[95:0]` is 0.
- R7: For a long reply, reply bits 127..0 (counting the start bit as bit 135) appear on `rsp_data[127:0]` as four big-endian words, with the first word in bits 127..96.
- R8: `err_hdr` is 1 exactly when either of the two leading bits of the reply's first byte is 1.
- R9: `err_crc` is 1 when the 7 bits before the reply's final bit differ from the CRC7 of the preceding content. The content is the 40 bits from the start bit for short kinds, or the 120 bits after the first byte for kind 3. The flag is never set for kind 4.
- R10: For kind 2, `done` is withheld after the reply until an edge samples `dat0_in` high, and rises right after that edge.
- R11: `done` lasts one cycle and `busy` is low in the next cycle. The result outputs keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CMD bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_idx | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_kind | input | 3 | Response kind code |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line sampled value |
| dat0_in | input | 1 | DAT0 line for busy signalling |
| rsp_data | output | 128 | Reply payload, big-endian words |
| err_timeout | output | 1 | No start bit within the window |
| err_hdr | output | 1 | Leading reply bits not zero |
| err_crc | output | 1 | Reply CRC7 mismatch |

## Verification
The token bits fall due on the 48 cycles after the accepting edge, so the bench samples `cmd_out` at the falling edge of each of those cycles. Kind none completes 48 edges after acceptance. A reply whose start bit is sampled g edges after the token completes g+L-1 edges later, and a busy reply completes one edge after DAT0 is first sampled high. A timeout completes exactly `RSP_TIMEOUT` edges after the token. The bench drives each reply bit at a falling edge and steps one cycle at a time. It checks at every intermediate cycle that `done` has not risen early and checks `done` and the results on the exact cycle the count predicts, then one cycle later for the pulse end.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [2:0] {
    RK_NONE        = 3'd0,
    RK_SHORT       = 3'd1,
    RK_SHORT_BUSY  = 3'd2,
    RK_LONG        = 3'd3,
    RK_SHORT_NOCRC = 3'd4
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RESP, ST_BUSYW, ST_FIN
  } eng_state_e;

  localparam int TOKEN_BITS = 48;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;

  function automatic logic kind_has_rsp(input logic [2:0] k);
    return (k >= 3'd1) && (k <= 3'd4);
  endfunction

  function automatic logic kind_is_long(input logic [2:0] k);
    return k == RK_LONG;
  endfunction

  function automatic logic kind_chk_crc(input logic [2:0] k);
    return (k >= 3'd1) && (k <= 3'd3);
  endfunction

  function automatic logic kind_wait_busy(input logic [2:0] k);
    return k == RK_SHORT_BUSY;
  endfunction

  // one CRC7 step, generator x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  // CRC7 over the low n bits of d, MSB first
  function automatic logic [6:0] crc7_calc(input logic [119:0] d, input int n);
    logic [6:0] c;
    c = 7'h00;
    for (int i = 119; i >= 0; i--) begin
      if (i < n) c = crc7_step(c, d[i]);
    end
    return c;
  endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  output logic        tx_bit,
  output logic        tx_active,
  output logic        tx_last
);
  localparam int CW = $clog2(TOKEN_BITS);
  localparam logic [CW-1:0] LAST_POS = CW'(TOKEN_BITS - 1);

  logic [TOKEN_BITS-1:0] sh;
  logic [CW-1:0]         pos;
  logic [39:0]           body;

  assign body = {2'b01, idx, arg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '1;
      pos       <= '0;
      tx_active <= 1'b0;
    end else if (load) begin
      sh        <= {body, crc7_calc({80'b0, body}, 40), 1'b1};
      pos       <= '0;
      tx_active <= 1'b1;
    end else if (tx_active) begin
      sh  <= {sh[TOKEN_BITS-2:0], 1'b1};
      pos <= pos + 1'b1;
      if (pos == LAST_POS) tx_active <= 1'b0;
    end
  end

  assign tx_bit  = tx_active ? sh[TOKEN_BITS-1] : 1'b1;
  assign tx_last = tx_active && (pos == LAST_POS);
endmodule

// File: rtl/sd_rsp_rx.sv
module sd_rsp_rx
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT = 64
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 long_sel,
  input  logic                 cmd_in,
  output logic [LONG_BITS-1:0] frame,
  output logic                 rx_done,
  output logic                 rx_timeout
);
  localparam int LW = $clog2(LONG_BITS + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {RX_OFF, RX_HUNT, RX_SHIFT} rx_state_e;

  rx_state_e     st;
  logic [LW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          long_q;
  logic [LW-1:0] last_idx;

  assign last_idx   = long_q ? LW'(LONG_BITS - 1) : LW'(SHORT_BITS - 1);
  assign rx_done    = (st == RX_SHIFT) && (cnt == last_idx);
  assign rx_timeout = (st == RX_HUNT) && cmd_in && (tcnt == TW'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_OFF;
      cnt    <= '0;
      tcnt   <= '0;
      long_q <= 1'b0;
      frame  <= '0;
    end else if (start) begin
      st     <= RX_HUNT;
      cnt    <= '0;
      tcnt   <= '0;
      long_q <= long_sel;
      frame  <= '0;
    end else begin
      case (st)
        RX_HUNT: begin
          if (!cmd_in) begin
            frame <= {frame[LONG_BITS-2:0], 1'b0};
            cnt   <= LW'(1);
            st    <= RX_SHIFT;
          end else if (rx_timeout) begin
            st <= RX_OFF;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_SHIFT: begin
          frame <= {frame[LONG_BITS-2:0], cmd_in};
          cnt   <= cnt + 1'b1;
          if (rx_done) st <= RX_OFF;
        end
        default: st <= RX_OFF;
      endcase
    end
  end
endmodule

// File: rtl/sd_rsp_check.sv
module sd_rsp_check
  import sd_cmd_pkg::*;
(
  input  logic [LONG_BITS-1:0] frame,
  input  logic [2:0]           kind,
  input  logic                 timed_out,
  output logic [127:0]         rsp_data,
  output logic                 hdr_bad,
  output logic                 crc_bad
);
  logic       valid, is_long;
  logic [7:0] first_byte;
  logic [6:0] crc_rx, crc_exp;

  assign valid   = kind_has_rsp(kind) && !timed_out;
  assign is_long = kind_is_long(kind);

  always_comb begin
    if (is_long) begin
      first_byte = frame[135:128];
      crc_exp    = crc7_calc(frame[127:8], 120);
    end else begin
      first_byte = frame[47:40];
      crc_exp    = crc7_calc({80'b0, frame[47:8]}, 40);
    end
    crc_rx = frame[7:1];
    if (!valid)       rsp_data = '0;
    else if (is_long) rsp_data = frame[127:0];
    else              rsp_data = {frame[39:8], 96'b0};
  end

  assign hdr_bad = valid && (first_byte[7:6] != 2'b00);
  assign crc_bad = valid && kind_chk_crc(kind) && (crc_rx != crc_exp);
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [5:0]   req_idx,
  input  logic [31:0]  req_arg,
  input  logic [2:0]   req_kind,
  output logic         busy,
  output logic         done,
  output logic         cmd_out,
  output logic         cmd_oe,
  input  logic         cmd_in,
  input  logic         dat0_in,
  output logic [127:0] rsp_data,
  output logic         err_timeout,
  output logic         err_hdr,
  output logic         err_crc
);
  eng_state_e           state;
  logic [2:0]           kind_q;
  logic                 accept, tx_last, tx_active;
  logic                 rx_start, rx_done, rx_timeout;
  logic [LONG_BITS-1:0] frame;

  assign accept   = req_valid && (state == ST_IDLE);
  assign rx_start = (state == ST_SEND) && tx_last && kind_has_rsp(kind_q);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign cmd_oe   = tx_active;

  sd_cmd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .idx(req_idx), .arg(req_arg),
    .tx_bit(cmd_out), .tx_active(tx_active), .tx_last(tx_last)
  );

  sd_rsp_rx #(.TIMEOUT(RSP_TIMEOUT)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .long_sel(kind_is_long(kind_q)),
    .cmd_in(cmd_in), .frame(frame), .rx_done(rx_done), .rx_timeout(rx_timeout)
  );

  sd_rsp_check u_chk_logic (
    .frame(frame), .kind(kind_q), .timed_out(err_timeout),
    .rsp_data(rsp_data), .hdr_bad(err_hdr), .crc_bad(err_crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      kind_q      <= RK_NONE;
      err_timeout <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state       <= ST_SEND;
          kind_q      <= req_kind;
          err_timeout <= 1'b0;
        end
        ST_SEND: if (tx_last) state <= kind_has_rsp(kind_q) ? ST_RESP : ST_FIN;
        ST_RESP: begin
          if (rx_done) begin
            state <= kind_wait_busy(kind_q) ? ST_BUSYW : ST_FIN;
          end else if (rx_timeout) begin
            state       <= ST_FIN;
            err_timeout <= 1'b1;
          end
        end
        ST_BUSYW: if (dat0_in) state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         busy,
  input logic         done,
  input logic         cmd_oe,
  input logic         tx_last,
  input logic         dat0_in,
  input logic [2:0]   kind_q,
  input logic         err_timeout,
  input logic         err_hdr,
  input logic         err_crc,
  input logic [127:0] rsp_data
);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R2
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R1
  oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy && !done);
  // R4
  release_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> !cmd_oe);
  // R3
  none_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && kind_q == 3'd0 |-> !err_timeout && !err_hdr && !err_crc && rsp_data == '0);
  // R5
  timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_timeout |-> !err_hdr && !err_crc && rsp_data == '0);
  // R9
  nocrc_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && kind_q == 3'd4 |-> !err_crc);
  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && kind_q == 3'd2 && !err_timeout |-> $past(dat0_in));
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_eng_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .done(done),
  .cmd_oe(cmd_oe), .tx_last(tx_last), .dat0_in(dat0_in), .kind_q(kind_q),
  .err_timeout(err_timeout), .err_hdr(err_hdr), .err_crc(err_crc),
  .rsp_data(rsp_data)
);

// File: tb/sd_cmd_engine_test.sv
module sd_cmd_engine_test;
  localparam int T = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [5:0]   req_idx = '0;
  logic [31:0]  req_arg = '0;
  logic [2:0]   req_kind = '0;
  logic         busy, done, cmd_out, cmd_oe;
  logic         cmd_in = 1'b1;
  logic         dat0_in = 1'b1;
  logic [127:0] rsp_data;
  logic         err_timeout, err_hdr, err_crc;

  int tests = 0;
  int fails = 0;
  logic [47:0] last_tok;

  always #2 clk = ~clk;

  sd_cmd_engine #(.RSP_TIMEOUT(T)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_arg(req_arg), .req_kind(req_kind), .busy(busy), .done(done),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat0_in(dat0_in),
    .rsp_data(rsp_data), .err_timeout(err_timeout), .err_hdr(err_hdr),
    .err_crc(err_crc)
  );

  // remainder of polynomial long division by 0x89 (x^7+x^3+1)
  function automatic logic [6:0] ref_crc(input logic [119:0] d, input int n);
    logic [126:0] v;
    v = {d, 7'b0};
    for (int i = n + 6; i >= 7; i--) begin
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    end
    return v[6:0];
  endfunction

  function automatic logic [47:0] ref_token(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] b;
    b = {2'b01, idx, arg};
    return {b, ref_crc({80'b0, b}, 40), 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [2:0] kind,
                         input int gap, input int blen, input bit bad_hdr, input bit bad_crc,
                         input bit poke);
    logic [47:0]  tok;
    logic [135:0] rb;
    logic [127:0] exp_rsp;
    logic [7:0]   b0;
    logic [31:0]  pw;
    logic [119:0] body;
    logic [6:0]   c;
    bit oe_ok, early, has_rsp, is_long, is_busy;
    int len;
    bit exp_crc;
    oe_ok = 1'b1; early = 1'b0;
    has_rsp = (kind >= 3'd1 && kind <= 3'd4);
    is_long = (kind == 3'd3);
    is_busy = (kind == 3'd2);
    @(negedge clk);
    req_valid = 1'b1; req_idx = idx; req_arg = arg; req_kind = kind;
    step();
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", 128'(busy), 128'd1);
    for (int i = 0; i < 48; i++) begin
      if (poke && i == 5) begin
        req_valid = 1'b1; req_idx = ~idx; req_arg = ~arg;
      end else req_valid = 1'b0;
      tok[47 - i] = cmd_out;
      oe_ok &= cmd_oe;
      step();
    end
    req_valid = 1'b0;
    last_tok = tok;
    chk(tok == ref_token(idx, arg), poke ? "R2 token unchanged by busy request" : "R1 token",
        128'(tok), 128'(ref_token(idx, arg)));
    chk(oe_ok && !cmd_oe && cmd_out, "R1 oe window", 128'({oe_ok, cmd_oe, cmd_out}), 128'b101);
    if (!has_rsp) begin
      chk(done && !err_timeout && !err_hdr && !err_crc && rsp_data == '0, "R3 none done",
          128'({done, err_timeout, err_hdr, err_crc}), 128'b1000);
    end else if (gap > T) begin
      for (int k = 1; k <= T; k++) begin
        if (k > 1) early |= done;
        step();
      end
      chk(!early, "R5 no early done", 128'(early), 128'd0);
      chk(done && err_timeout && !err_hdr && !err_crc && rsp_data == '0, "R5 timeout",
          128'({done, err_timeout, err_hdr, err_crc}), 128'b1100);
    end else begin
      b0 = {1'b0, bad_hdr, idx};
      if (is_long) begin
        b0   = {1'b0, bad_hdr, 6'h3F};
        body = {$urandom(), $urandom(), $urandom(), 24'($urandom())};
        c    = ref_crc(body, 120) ^ {6'b0, bad_crc};
        rb   = {b0, body, c, 1'b1};
        exp_rsp = {body, c, 1'b1};
        len = 136;
      end else begin
        pw = $urandom();
        c  = ref_crc({80'b0, b0, pw}, 40) ^ {6'b0, bad_crc};
        rb = {88'b0, b0, pw, c, 1'b1};
        exp_rsp = {pw, 96'b0};
        len = 48;
      end
      exp_crc = bad_crc && (kind != 3'd4);
      for (int k = 1; k < gap; k++) begin
        early |= done;
        step();
      end
      for (int j = 0; j < len; j++) begin
        cmd_in = rb[len - 1 - j];
        if (j == len - 1 && is_busy) dat0_in = 1'b0;
        early |= done;
        step();
      end
      cmd_in = 1'b1;
      if (is_busy) begin
        for (int b = 0; b < blen; b++) begin
          early |= done;
          step();
        end
        early |= done;
        dat0_in = 1'b1;
        step();
        chk(!early && done, "R10 done after dat0 high", 128'({early, done}), 128'b01);
      end else begin
        chk(!early && done, "R4 done after last bit", 128'({early, done}), 128'b01);
      end
      chk(rsp_data == exp_rsp, is_long ? "R7 long words" : "R6 short word", rsp_data, exp_rsp);
      chk(err_hdr == bad_hdr, "R8 header flag", 128'(err_hdr), 128'(bad_hdr));
      chk(err_crc == exp_crc, "R9 crc flag", 128'(err_crc), 128'(exp_crc));
      chk(!err_timeout, "R4 no timeout", 128'(err_timeout), 128'd0);
    end
    exp_rsp = rsp_data;
    step();
    chk(!done && !busy, "R11 pulse end", 128'({done, busy}), 128'b00);
    chk(rsp_data == exp_rsp, "R11 result held", rsp_data, exp_rsp);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5D17));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_oe && cmd_out, "R11 reset state",
        128'({busy, done, cmd_oe, cmd_out}), 128'b0001);
    rst_n = 1'b1;
    step();
    // R1 known CRC values
    run_cmd(6'd0, 32'h0, 3'd0, 1, 0, 0, 0, 0);
    chk(last_tok[7:0] == 8'h95, "R1 CMD0 tail", 128'(last_tok[7:0]), 128'h95);
    run_cmd(6'd8, 32'h1AA, 3'd1, 2, 0, 0, 0, 0);
    chk(last_tok[7:0] == 8'h87, "R1 CMD8 tail", 128'(last_tok[7:0]), 128'h87);
    // R3 unused code acts as none
    run_cmd(6'd5, 32'h1234, 3'd6, 1, 0, 0, 0, 0);
    // R2 busy request ignored
    run_cmd(6'd17, 32'hCAFE0001, 3'd1, 1, 0, 0, 0, 1);
    // R5 timeout and boundary start bit
    run_cmd(6'd2, 32'h0, 3'd3, T + 1, 0, 0, 0, 0);
    run_cmd(6'd3, 32'h0, 3'd1, T, 0, 0, 0, 0);
    // R8 header, R9 crc, kind 4 masking
    run_cmd(6'd13, 32'h0, 3'd1, 3, 0, 1, 0, 0);
    run_cmd(6'd13, 32'h0, 3'd1, 3, 0, 0, 1, 0);
    run_cmd(6'd41, 32'h40FF8000, 3'd4, 4, 0, 0, 1, 0);
    run_cmd(6'd9, 32'h0, 3'd3, 2, 0, 0, 1, 0);
    // R10 busy lengths
    run_cmd(6'd7, 32'h00010000, 3'd2, 2, 0, 0, 0, 0);
    run_cmd(6'd7, 32'h00010000, 3'd2, 2, 9, 0, 0, 0);
    for (int n = 0; n < 40; n++) begin
      run_cmd(6'($urandom()), $urandom(), 3'($urandom_range(0, 4)),
              $urandom_range(1, 8), $urandom_range(0, 6),
              ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule